// File: doc/BRIEF.md
# Multi-Cycle Signed Arithmetic Unit

This block computes sums, differences, products and quotients of two signed two's-complement words. A requester places an opcode and two operands on the inputs and raises a start request. The unit captures them, works for one or more clock cycles, and raises a done flag with the result. For division, a second output carries the remainder. The done flag stays high until the requester lowers start. Only after done has dropped will the unit accept another request.

Faults are reported on a separate error flag that completes the same handshake. These faults are a sum, difference or product that does not fit in the word, a zero divisor, and the most negative value divided by minus one. Division runs a restoring shift-subtract loop over the operand magnitudes. The quotient is truncated toward zero, and the remainder is given as its magnitude, which is never negative.

Top module: `arith_unit`

## Requirements
- R1: While reset (rstN low) is asserted, and after it is released, done, error, result and remainder are all zero until the first request is accepted.
- R2: A request is accepted when start is high and done is low. Done then rises and stays high while start stays high. Done falls one cycle after start is sampled low. It stays low until the next request.
- R3: Opcodes are 3'd0 no-op, 3'd1 add, 3'd2 subtract, 3'd3 multiply and 3'd4 divide; codes 3'd5 to 3'd7 act as no-op. Done is visible one cycle after acceptance for every opcode except a divide that runs, and 34 cycles after acceptance for a divide that runs.
- R4: Add and subtract return the wrapped 32-bit result. Error is raised when the signed result overflows. A result of exactly -2147483648 is legal.
- R5: Multiply returns the exact product when it fits in signed 32 bits. Otherwise it raises error.
- R6: The divide quotient is truncated toward zero and is negative exactly when the operand signs differ and the quotient is non-zero.
- R7: After a divide, remainder is the magnitude of the true remainder and is never negative. A divisor of -2147483648 with a smaller dividend gives quotient 0 and the dividend's magnitude as remainder.
- R8: A divide by zero, and -2147483648 divided by -1, raise error and complete one cycle after acceptance.
- R9: A no-op completes with result and remainder zero and error low. Add, subtract and multiply leave remainder zero.
- R10: When error is raised, result and remainder are zero.
- R11: Result, remainder and error stay stable while done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| opcode | input | 3 | Operation select (see R3) |
| operandA | input | 32 | First operand, signed (dividend, minuend) |
| operandB | input | 32 | Second operand, signed (divisor, subtrahend) |
| start | input | 1 | Request; held high until done is seen |
| result | output | 32 | Sum, difference, product or quotient |
| remainder | output | 32 | Remainder magnitude after a divide |
| done | output | 1 | Result valid; held until start falls |
| error | output | 1 | Overflow or divide fault for the completed operation |

## Verification
Inputs are driven on the falling edge, and the request is taken at the next rising edge. Add, subtract, multiply, no-op and faulting divides must then show done at the first falling edge after that. A divide that runs must show done at the 34th falling edge. Each scenario counts falling edges from raising start until done appears. It compares that count with the latency expected for the operation, and only then samples result, remainder and error. It keeps start high for two more edges to confirm the outputs hold. Then it lowers start and expects done low at the very next falling edge.

// File: rtl/arith_pkg.sv
`timescale 1ns/1ps
package arith_pkg;

  typedef enum logic [2:0] {
    OP_NOP = 3'd0,
    OP_ADD = 3'd1,
    OP_SUB = 3'd2,
    OP_MUL = 3'd3,
    OP_DIV = 3'd4
  } arith_op_e;

  typedef struct packed {
    logic load;    // capture operands, compute single-cycle ops
    logic step;    // one restoring-division iteration
    logic finish;  // apply quotient sign, publish divide result
  } arith_strobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CALC = 2'd1,
    ST_FIN  = 2'd2,
    ST_DONE = 2'd3
  } arith_state_e;

endpackage

// File: rtl/arith_ctrl.sv
`timescale 1ns/1ps
module arith_ctrl
  import arith_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          isDiv,
  input  logic          divFault,
  output arith_strobe_t strobe,
  output logic          done
);

  localparam int CNT_W = $clog2(WIDTH);
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(WIDTH - 1);

  arith_state_e stateQ, stateD;
  logic [CNT_W-1:0] stepCnt;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE: if (start) stateD = (isDiv && !divFault) ? ST_CALC : ST_DONE;
      ST_CALC: if (stepCnt == LAST_STEP) stateD = ST_FIN;
      ST_FIN:  stateD = ST_DONE;
      ST_DONE: if (!start) stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      stepCnt <= '0;
    end else begin
      stateQ <= stateD;
      if (stateQ == ST_IDLE)      stepCnt <= '0;
      else if (stateQ == ST_CALC) stepCnt <= stepCnt + 1'b1;
    end
  end

  always_comb begin
    strobe.load   = (stateQ == ST_IDLE) && start;
    strobe.step   = (stateQ == ST_CALC);
    strobe.finish = (stateQ == ST_FIN);
  end

  assign done = (stateQ == ST_DONE);

  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (done && start) |=> done); // R2
  AST_DONE_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> !done); // R2
  AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.load, strobe.step, strobe.finish, done})); // R2

endmodule

// File: rtl/arith_datapath.sv
`timescale 1ns/1ps
module arith_datapath
  import arith_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  arith_strobe_t    strobe,
  input  logic [2:0]       opcode,
  input  logic [WIDTH-1:0] operandA,
  input  logic [WIDTH-1:0] operandB,
  output logic             isDiv,
  output logic             divFault,
  output logic [WIDTH-1:0] resultQ,
  output logic [WIDTH-1:0] remQ,
  output logic             errorQ
);

  localparam int PROD_W = 2 * WIDTH;
  localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};
  localparam logic [WIDTH-1:0] MINUS_ONE = '1;

  // single-cycle arithmetic on the live operands
  logic [WIDTH-1:0]  sumVal, diffVal;
  logic              sumOvf, diffOvf, mulOvf;
  logic [PROD_W-1:0] prodVal;
  logic [WIDTH:0]    prodTop;

  always_comb begin
    sumVal  = operandA + operandB;
    diffVal = operandA - operandB;
    sumOvf  = (operandA[WIDTH-1] == operandB[WIDTH-1]) &&
              (sumVal[WIDTH-1] != operandA[WIDTH-1]);
    diffOvf = (operandA[WIDTH-1] != operandB[WIDTH-1]) &&
              (diffVal[WIDTH-1] != operandA[WIDTH-1]);
    prodVal = PROD_W'($signed(operandA) * $signed(operandB));
    prodTop = prodVal[PROD_W-1:WIDTH-1];
    mulOvf  = (prodTop != '0) && (prodTop != '1);
  end

  assign isDiv    = (opcode == OP_DIV);
  assign divFault = (operandB == '0) ||
                    ((operandA == MOST_NEG) && (operandB == MINUS_ONE));

  // magnitudes for the divider; MOST_NEG maps to 2^(WIDTH-1) unsigned
  logic [WIDTH-1:0] magA, magB;
  assign magA = operandA[WIDTH-1] ? (~operandA + 1'b1) : operandA;
  assign magB = operandB[WIDTH-1] ? (~operandB + 1'b1) : operandB;

  // divider state
  logic [WIDTH-1:0] quoShift, remAcc, divisorMag;
  logic             negQuo;
  logic [WIDTH:0]   trialShift, trialDiff;
  logic             quoBit;

  always_comb begin
    trialShift = {remAcc, quoShift[WIDTH-1]};
    trialDiff  = trialShift - {1'b0, divisorMag};
    quoBit     = !trialDiff[WIDTH];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      quoShift   <= '0;
      remAcc     <= '0;
      divisorMag <= '0;
      negQuo     <= 1'b0;
    end else if (strobe.load) begin
      quoShift   <= magA;
      remAcc     <= '0;
      divisorMag <= magB;
      negQuo     <= operandA[WIDTH-1] ^ operandB[WIDTH-1];
    end else if (strobe.step) begin
      quoShift <= {quoShift[WIDTH-2:0], quoBit};
      remAcc   <= quoBit ? trialDiff[WIDTH-1:0] : trialShift[WIDTH-1:0];
    end
  end

  // published results
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultQ <= '0;
      remQ    <= '0;
      errorQ  <= 1'b0;
    end else if (strobe.load) begin
      remQ <= '0;
      unique case (opcode)
        OP_ADD: begin
          errorQ  <= sumOvf;
          resultQ <= sumOvf ? '0 : sumVal;
        end
        OP_SUB: begin
          errorQ  <= diffOvf;
          resultQ <= diffOvf ? '0 : diffVal;
        end
        OP_MUL: begin
          errorQ  <= mulOvf;
          resultQ <= mulOvf ? '0 : prodVal[WIDTH-1:0];
        end
        OP_DIV: begin
          errorQ  <= divFault;
          resultQ <= '0;
        end
        default: begin
          errorQ  <= 1'b0;
          resultQ <= '0;
        end
      endcase
    end else if (strobe.finish) begin
      resultQ <= negQuo ? (~quoShift + 1'b1) : quoShift;
      remQ    <= remAcc;
    end
  end

  AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rstN)
    strobe.finish |-> (remAcc < divisorMag)); // R7
  AST_FAULT_SKIPS_LOOP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && isDiv && divFault) |=> !strobe.step); // R8

endmodule

// File: rtl/arith_unit.sv
`timescale 1ns/1ps
module arith_unit
  import arith_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       opcode,
  input  logic [WIDTH-1:0] operandA,
  input  logic [WIDTH-1:0] operandB,
  input  logic             start,
  output logic [WIDTH-1:0] result,
  output logic [WIDTH-1:0] remainder,
  output logic             done,
  output logic             error
);

  arith_strobe_t strobe;
  logic isDiv, divFault;

  arith_ctrl #(.WIDTH(WIDTH)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .isDiv    (isDiv),
    .divFault (divFault),
    .strobe   (strobe),
    .done     (done)
  );

  arith_datapath #(.WIDTH(WIDTH)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .opcode   (opcode),
    .operandA (operandA),
    .operandB (operandB),
    .isDiv    (isDiv),
    .divFault (divFault),
    .resultQ  (result),
    .remQ     (remainder),
    .errorQ   (error)
  );

  AST_RESULT_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (done && $past(done)) |-> ($stable(result) && $stable(remainder) && $stable(error))); // R11
  AST_REM_POSITIVE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !remainder[WIDTH-1]); // R7
  AST_DIV_ZERO_ERR: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(done) && opcode == OP_DIV && operandB == '0) |-> error); // R8
  AST_NOP_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(done) && opcode == OP_NOP) |-> (!error && result == '0 && remainder == '0)); // R9
  AST_ERR_ZEROED: assert property (@(posedge clk) disable iff (!rstN)
    (done && error) |-> (result == '0 && remainder == '0)); // R10

endmodule

// File: tb/arith_unit_tb_top.sv
`timescale 1ns/1ps
module arith_unit_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  opcode = 3'd0;
  logic [31:0] operandA = '0, operandB = '0;
  logic        start = 1'b0;
  logic [31:0] result, remainder;
  logic        done, error;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;  // 4 ns period

  arith_unit dut_i (
    .clk(clk), .rstN(rstN), .opcode(opcode), .operandA(operandA),
    .operandB(operandB), .start(start), .result(result),
    .remainder(remainder), .done(done), .error(error)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d (0x%08h) expected %0d (0x%08h)", req, $signed(act), act, $signed(exp), exp);
    end
  endtask

  // one operation through the full handshake
  task automatic runOp(input string tag, input logic [2:0] op, input int a, input int b,
                       input int expQ, input int expR, input logic expErr, input int expLat);
    int lat;
    logic [31:0] q0;
    @(negedge clk);
    opcode = op; operandA = a; operandB = b; start = 1'b1;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!done && lat < 100);
    chk({tag, " R3 latency"}, lat, expLat);
    chk({tag, " R10 error"}, {31'b0, error}, {31'b0, expErr});
    chk({tag, " result"}, result, expErr ? 32'd0 : expQ);
    chk({tag, " R7 remainder"}, remainder, expErr ? 32'd0 : expR);
    q0 = result;
    repeat (2) @(negedge clk);
    chk({tag, " R2 done held"}, {31'b0, done}, 32'd1);
    chk({tag, " R11 result held"}, result, q0);
    start = 1'b0;
    @(negedge clk);
    chk({tag, " R2 done dropped"}, {31'b0, done}, 32'd0);
    @(negedge clk);
    chk({tag, " R2 stays idle"}, {31'b0, done}, 32'd0);
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    chk("R1 done in reset", {31'b0, done}, 32'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 done", {31'b0, done}, 32'd0);
    chk("R1 error", {31'b0, error}, 32'd0);
    chk("R1 result", result, 32'd0);
    chk("R1 remainder", remainder, 32'd0);
  endtask

  task automatic testAddSub();
    runOp("R4 add", 3'd1, 7, 3, 10, 0, 1'b0, 1);
    runOp("R4 add neg", 3'd1, -7, -1, -8, 0, 1'b0, 1);
    runOp("R4 add ovf", 3'd1, 2147483647, 1, 0, 0, 1'b1, 1);
    runOp("R4 add unf", 3'd1, -2147483645, -100, 0, 0, 1'b1, 1);
    runOp("R4 sub to min", 3'd2, -2147483647, 1, 32'h8000_0000, 0, 1'b0, 1);
    runOp("R4 sub min", 3'd2, 5, 32'h8000_0000, 0, 0, 1'b1, 1);
    runOp("R4 sub unf", 3'd2, -1000, 2147483645, 0, 0, 1'b1, 1);
  endtask

  task automatic testMul();
    runOp("R5 mul", 3'd3, -7, 3, -21, 0, 1'b0, 1);
    runOp("R5 mul big", 3'd3, 268435456, -2, -536870912, 0, 1'b0, 1);
    runOp("R5 mul ovf", 3'd3, 90000, 100000, 0, 0, 1'b1, 1);
    runOp("R5 mul ovf neg", 3'd3, -90000, 100000, 0, 0, 1'b1, 1);
    runOp("R5 mul ovf nn", 3'd3, -90000, -100000, 0, 0, 1'b1, 1);
  endtask

  task automatic testDiv();
    runOp("R6 div neg/pos", 3'd4, -5, 3, -1, 2, 1'b0, 34);
    runOp("R6 div", 3'd4, -153156, 3543, -43, 807, 1'b0, 34);
    runOp("R6 div pos/neg", 3'd4, 153156, -3543, -43, 807, 1'b0, 34);
    runOp("R6 div neg/neg", 3'd4, -153156, -3543, 43, 807, 1'b0, 34);
    runOp("R7 div min", 3'd4, 32'h8000_0000, 10, -214748364, 8, 1'b0, 34);
    runOp("R7 div by min", 3'd4, 1, 32'h8000_0000, 0, 1, 1'b0, 34);
    runOp("R6 div large", 3'd4, 5134123, 358015, 14, 121913, 1'b0, 34);
  endtask

  task automatic testDivFault();
    runOp("R8 div zero", 3'd4, 32'h8000_0000, 0, 0, 0, 1'b1, 1);
    runOp("R8 min by -1", 3'd4, 32'h8000_0000, -1, 0, 0, 1'b1, 1);
  endtask

  task automatic testNop();
    runOp("R9 nop", 3'd0, 123, 456, 0, 0, 1'b0, 1);
    runOp("R9 spare code", 3'd7, -1, -1, 0, 0, 1'b0, 1);
    runOp("R9 add clears rem", 3'd1, -7, 1, -6, 0, 1'b0, 1);
  endtask

  initial begin
    testReset();
    testAddSub();
    testMul();
    testDiv();
    runOp("R9 rem cleared after div", 3'd3, 3, -2, -6, 0, 1'b0, 1);
    testDivFault();
    testNop();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule